// File: doc/BRIEF.md
# Gated Binary Clock Divider

This block derives three clocks from one input clock: half, quarter and eighth rate. All three are bits of one three-bit binary counter, and that counter is clocked by a single internal clock. When two outputs change together, they therefore change on the same rising edge of the input clock, with no ripple between stages.

An active-low run input, `en_n`, can stop the divider. A register samples it on each falling edge of the input clock. That register gates the counter's clock, and it changes only while the input clock is low, so the counter never receives a shortened pulse. A stopped divider keeps its count. When it restarts, it continues from that count, so the output sequence is the uninterrupted sequence with some edges skipped.

An active-high master reset `mr` clears every output at once. It is released on the falling edge of the clock, so several dividers that share `mr` and the clock start counting on the same edge.

Top module: `clkdiv_sync_en`

## Requirements
- R1: The three outputs are the bits of a binary count of the rising clock edges the divider accepts: `q_div2` is bit 0, `q_div4` is bit 1 and `q_div8` is bit 2. After 7 comes 0, and all three outputs fall on that same edge.
- R2: If `en_n` is low at a falling clock edge, the next rising edge advances the count by exactly one.
- R3: If `en_n` is high at a falling clock edge, the next rising edge is ignored and the outputs hold. Once `en_n` is low again, counting resumes from the held value.
- R4: A change of `en_n` that is undone before the next falling edge has no effect on the count. This holds whether the change happens while the clock is high or while it is low.
- R5: While `mr` is high, all true outputs are low at once, without waiting for a clock edge. This holds whatever `clk` and `en_n` are doing.
- R6: After `mr` falls, the count stays at zero until two falling clock edges have passed. The rising edge after those two is the first one that can be counted.
- R7: Reset leaves the enable register in the run state. The first rising edge after the release in R6 is therefore counted even if `en_n` is high. From then on, `en_n` is sampled as in R2 and R3.
- R8: Each `_n` output is the exact inverse of its true output at all times, including during reset.
- R9: `q_div4` changes only on an edge where `q_div2` falls. `q_div8` changes only on an edge where `q_div4` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| en_n | input | 1 | Active-low run control, sampled on falling clock edges |
| mr | input | 1 | Active-high master reset, asynchronous assertion |
| q_div2 | output | 1 | Half-rate clock |
| q_div2_n | output | 1 | Inverse of `q_div2` |
| q_div4 | output | 1 | Quarter-rate clock |
| q_div4_n | output | 1 | Inverse of `q_div4` |
| q_div8 | output | 1 | Eighth-rate clock |
| q_div8_n | output | 1 | Inverse of `q_div8` |

## Verification
The hardest case to produce from the ports is a run-control change that falls entirely inside one half of a clock period. This is exactly the case that could cut the gated clock short. The bench produces it by driving `en_n` with sub-period delays, once while the clock is high and once between a falling edge and the following rising edge. It then checks that no count was lost.

A second case that is easy to miss is reset release with `en_n` already high. The bench holds the divider stopped across the release. It then confirms that exactly one edge is counted before the stop takes hold.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  // Number of binary divider stages (2^1 .. 2^DIV_STAGES)
  localparam int DIV_STAGES  = 3;
  // Falling-edge flops used to release the internal reset
  localparam int SYNC_STAGES = 2;

  typedef logic [DIV_STAGES-1:0] div_count_t;
endpackage

// File: rtl/clkdiv_rst_sync.sv
`timescale 1ns/1ps
// Asserts the internal active-low reset asynchronously and releases it on a
// falling clock edge, so release can never cut a gated-clock high phase.
module clkdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  output logic rst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(negedge clk or posedge arst) begin
    if (arst) chain_q <= '0;
    else      chain_q <= chain_d;
  end

  assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/clkdiv_hold_reg.sv
`timescale 1ns/1ps
// Falling-edge register for the run control. Its output only moves while
// clk is low, which keeps the downstream AND gate free of runt pulses.
module clkdiv_hold_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic en_n,
  output logic hold_q
);
  logic hold_d;

  always_comb begin
    hold_d = en_n;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end
endmodule

// File: rtl/clkdiv_clk_gate.sv
`timescale 1ns/1ps
// AND-type clock gate; safe because hold_q changes only while clk is low.
module clkdiv_clk_gate (
  input  logic clk,
  input  logic hold_q,
  output logic gclk
);
  assign gclk = clk & ~hold_q;
endmodule

// File: rtl/clkdiv_counter.sv
`timescale 1ns/1ps
// Binary counter on the gated clock; every bit switches on the same edge.
module clkdiv_counter #(
  parameter int WIDTH = 3
) (
  input  logic             gclk,
  input  logic             rst_n,
  output logic [WIDTH-1:0] cnt_q
);
  logic [WIDTH-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + WIDTH'(1);
  end

  always_ff @(posedge gclk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/clkdiv_sync_en.sv
`timescale 1ns/1ps
module clkdiv_sync_en
  import clkdiv_pkg::*;
(
  input  logic clk,
  input  logic en_n,
  input  logic mr,
  output logic q_div2,
  output logic q_div2_n,
  output logic q_div4,
  output logic q_div4_n,
  output logic q_div8,
  output logic q_div8_n
);
  logic       rst_n;
  logic       hold_q;
  logic       gclk;
  div_count_t cnt_q;
  div_count_t cnt_n;

  clkdiv_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk   (clk),
    .arst  (mr),
    .rst_n (rst_n)
  );

  clkdiv_hold_reg u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_n   (en_n),
    .hold_q (hold_q)
  );

  clkdiv_clk_gate u_gate (
    .clk    (clk),
    .hold_q (hold_q),
    .gclk   (gclk)
  );

  clkdiv_counter #(.WIDTH(DIV_STAGES)) u_cnt (
    .gclk  (gclk),
    .rst_n (rst_n),
    .cnt_q (cnt_q)
  );

  // Complement per stage
  for (genvar g = 0; g < DIV_STAGES; g++) begin : g_inv
    assign cnt_n[g] = ~cnt_q[g];
  end

  assign q_div2   = cnt_q[0];
  assign q_div4   = cnt_q[1];
  assign q_div8   = cnt_q[2];
  assign q_div2_n = cnt_n[0];
  assign q_div4_n = cnt_n[1];
  assign q_div8_n = cnt_n[2];
endmodule

// File: rtl/clkdiv_sync_en_chk.sv
`timescale 1ns/1ps
module clkdiv_sync_en_chk (
  input logic clk,
  input logic mr,
  input logic rst_n,
  input logic hold_q,
  input logic q_div2,
  input logic q_div2_n,
  input logic q_div4,
  input logic q_div4_n,
  input logic q_div8,
  input logic q_div8_n
);
  logic [2:0] outs;
  assign outs = {q_div8, q_div4, q_div2};

  // R8
  compl_match_chk: assert property (@(negedge clk) disable iff (mr || !rst_n)
    (q_div2_n == !q_div2) && (q_div4_n == !q_div4) && (q_div8_n == !q_div8));

  // R5
  always @(negedge clk) begin
    if (mr === 1'b1) begin
      reset_low_chk: assert (outs == 3'b000);
    end
  end

  // R3
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |=> $stable(outs));

  // R2
  run_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_q |=> (outs == 3'($past(outs) + 3'd1)));

  // R9
  div4_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_div4 != $past(q_div4)) |-> ($past(q_div2) && !q_div2));

  // R9
  div8_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_div8 != $past(q_div8)) |-> ($past(q_div4) && !q_div4));
endmodule

bind clkdiv_sync_en clkdiv_sync_en_chk u_chk (
  .clk      (clk),
  .mr       (mr),
  .rst_n    (rst_n),
  .hold_q   (hold_q),
  .q_div2   (q_div2),
  .q_div2_n (q_div2_n),
  .q_div4   (q_div4),
  .q_div4_n (q_div4_n),
  .q_div8   (q_div8),
  .q_div8_n (q_div8_n)
);

// File: tb/sim_clkdiv_sync_en.sv
`timescale 1ns/1ps
module sim_clkdiv_sync_en;
  logic clk;
  logic en_n;
  logic mr;
  logic q_div2, q_div2_n, q_div4, q_div4_n, q_div8, q_div8_n;
  int   checks;
  int   failures;
  bit   done;

  clkdiv_sync_en u0 (
    .clk      (clk),
    .en_n     (en_n),
    .mr       (mr),
    .q_div2   (q_div2),
    .q_div2_n (q_div2_n),
    .q_div4   (q_div4),
    .q_div4_n (q_div4_n),
    .q_div8   (q_div8),
    .q_div8_n (q_div8_n)
  );

  // 250 MHz: rising edges at 2, 6, 10 ... ns
  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  // {en_n driven before the edge, expected count after it}
  localparam logic [3:0] VECS [16] = '{
    4'b0_001, 4'b0_010, 4'b0_011, 4'b1_011,
    4'b1_011, 4'b0_100, 4'b0_101, 4'b0_110,
    4'b0_111, 4'b0_000, 4'b1_000, 4'b0_001,
    4'b0_010, 4'b0_011, 4'b0_100, 4'b0_101
  };

  task automatic chk(input string tag, input logic [2:0] exp);
    logic [2:0] act;
    logic [2:0] actn;
    act  = {q_div8, q_div4, q_div2};
    actn = {q_div8_n, q_div4_n, q_div2_n};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s count actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
    checks++;
    if (actn !== ~exp) begin
      failures++;
      $display("FAIL R8 (%s) complement actual=%b expected=%b at %0t", tag, actn, ~exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    checks   = 0;
    failures = 0;
    done     = 1'b0;
    mr       = 1'b1;
    en_n     = 1'b0;

    // R5 / R8: reset state with the clock running
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R5 reset state", 3'b000);
    end

    // R6: release, nothing counted until two falling edges have passed
    mr = 1'b0;
    step();
    chk("R6 release delay", 3'b000);

    // R1 / R2 / R3 / R9: vector table, includes hold and 7->0 wrap
    for (int i = 0; i < 16; i++) begin
      en_n = VECS[i][3];
      step();
      chk(VECS[i][3] ? "R3 hold" : "R1 R2 R9 count", VECS[i][2:0]);
    end

    // R4: en_n pulse while clk is high, gone before the falling edge
    #0.5 en_n = 1'b1;
    #0.3 en_n = 1'b0;
    step();
    chk("R4 pulse while high", 3'b110);

    // R4: en_n pulse after the falling edge, gone before the next one
    #1.5 en_n = 1'b1;
    #1.0 en_n = 1'b0;
    step();
    chk("R4 pulse while low", 3'b111);

    // R3: freeze, then R5 asynchronous reset while frozen
    en_n = 1'b1;
    step();
    chk("R3 freeze", 3'b111);
    #0.5 mr = 1'b1;
    #0.2;
    chk("R5 async clear", 3'b000);

    // R7: release with en_n held high; one edge counts, then held
    step();
    mr = 1'b0;
    step();
    chk("R6 R7 release", 3'b000);
    step();
    chk("R7 first edge counts", 3'b001);
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R7 then held", 3'b001);
    end

    // R3: resume from held value
    en_n = 1'b0;
    step();
    chk("R3 resume", 3'b010);
    step();
    chk("R2 continue", 3'b011);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule